// File: doc/BRIEF.md
# Remappable peripheral pin crossbar

This block sits between a group of remappable device pins and the digital peripherals that may use them. It is configured at run time. Routing in each direction is chosen from a different side. Each peripheral input owns a select field that names the pin feeding it. Each pin owns a select field that names the peripheral output driving it; a zero code leaves the pin with its ordinary GPIO data and direction. Nothing stops one pin from feeding several peripheral inputs, or one peripheral output from driving several pins.

The mapping registers are written over a simple synchronous register bus and read back through a registered data port. A lock bit guards them. The lock bit changes only through a two-byte key sequence written to the control register. An external one-way input, when asserted, makes the lock permanent once it has been set. A shadow copy of every mapping field is compared against the live copy on every cycle. Any difference that a legal write did not cause raises a sticky reset request. A fault-injection input can flip one live configuration bit, so that this detection path can be exercised.

All pin and peripheral outputs are registered, so every routing path has one clock of latency.

Top module: `pin_xbar`

## Requirements
- R1: Input select field i sits at bus address 1+i, bits 5:0. A value k below NUM_PINS routes pin_in[k] to periph_in[i].
- R2: Input select fields reset to 6'h3F. Any select value of NUM_PINS or above drives its periph_in bit to 0.
- R3: Output code 0 is the reset value. With code 0, pin_out[p] follows gpio_dout[p] and pin_oe[p] follows gpio_oe[p].
- R4: A nonzero output code c below NUM_CODES drives pin_out[p] from periph_out[c] and pin_oe[p] from periph_oe[c]. A code of NUM_CODES or above leaves the pin undriven, with pin_oe=0 and pin_out=0.
- R5: Output select register m is at address 16+m. It holds pin 2m in bits 5:0 and pin 2m+1 in bits 13:8. Bits 7:6 read as 0.
- R6: There is no lockout between mappings. Several inputs may select the same pin, and several pins may carry the same output code.
- R7: The control register is at address 0, with the lock bit at bit 0 (1 = locked), and it resets to 0. While locked, writes to mapping addresses leave every field unchanged.
- R8: The lock bit takes the value of wdata[0] only on the control write that directly follows control writes of 8'h46 and then 8'h57 in the low byte.
- R9: Any write that is not the expected next key byte returns the key sequence to idle. This includes a write to any other address.
- R10: While one_way_lock is 1, a set lock bit cannot be cleared.
- R11: cfg_mismatch rises one cycle after a live configuration bit is upset, and it stays high until reset. Legal writes never raise it.
- R12: periph_in, pin_out and pin_oe are registered. They reflect pin, GPIO and peripheral inputs one clock after those inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 14 | Write data |
| bus_rdata | output | 14 | Registered read data for bus_addr |
| one_way_lock | input | 1 | Makes a set lock permanent |
| fault_inj_en | input | 1 | Flip one live configuration bit |
| fault_inj_bit | input | 7 | Index of the bit to flip |
| pin_in | input | NUM_PINS | Pad input levels |
| gpio_dout | input | NUM_PINS | GPIO latch data |
| gpio_oe | input | NUM_PINS | GPIO drive enable (1 = drive) |
| periph_out | input | NUM_CODES-1 | Peripheral output data, indexed by code 1..NUM_CODES-1 |
| periph_oe | input | NUM_CODES-1 | Peripheral output enables, indexed by code |
| pin_out | output | NUM_PINS | Pad output data |
| pin_oe | output | NUM_PINS | Pad output enable |
| periph_in | output | NUM_IN | Peripheral input levels |
| cfg_mismatch | output | 1 | Configuration-mismatch reset request |

## Verification
The hardest case to reach is a difference between the live and shadow copies that no legal write caused. Every write path updates both copies together, so ordinary bus traffic cannot create one. The stimulus flips a chosen live bit through the fault-injection input. It then confirms that the request rises one cycle later, stays high across later writes, and clears only on reset. The key sequence is the other subtle area. Interrupted, repeated and interleaved key bytes are written, and afterwards the lock bit is read back to show that no lock change took effect.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int SEL_W = 6;
  localparam int BUS_W = 14;
  localparam logic [7:0] KEY_FIRST  = 8'h46;
  localparam logic [7:0] KEY_SECOND = 8'h57;
  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_OPEN} key_state_t;
endpackage

// File: rtl/pxb_lock.sv
module pxb_lock
  import pxb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic       other_wr,
  input  logic [7:0] wbyte,
  input  logic       one_way,
  output logic       locked
);
  key_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= KEY_IDLE;
      locked <= 1'b0;
    end else if (ctrl_wr) begin
      case (st)
        KEY_IDLE: st <= (wbyte == KEY_FIRST)  ? KEY_HALF : KEY_IDLE;
        KEY_HALF: st <= (wbyte == KEY_SECOND) ? KEY_OPEN : KEY_IDLE;
        default: begin
          st     <= KEY_IDLE;
          locked <= (one_way && locked) ? 1'b1 : wbyte[0];
        end
      endcase
    end else if (other_wr) begin
      st <= KEY_IDLE;
    end
  end
endmodule

// File: rtl/pxb_cfg.sv
module pxb_cfg
  import pxb_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_IN   = 6,
  parameter int ADDR_W   = 5,
  parameter int IN_BASE  = 1,
  parameter int OUT_BASE = 16,
  localparam int TOT     = (NUM_IN + NUM_PINS) * SEL_W,
  localparam int INJ_W   = $clog2(TOT)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              inj_en,
  input  logic [INJ_W-1:0]  inj_bit,
  output logic [TOT-1:0]    cfg_flat,
  output logic              mismatch
);
  localparam logic [TOT-1:0] RST_VAL =
    {{(NUM_PINS*SEL_W){1'b0}}, {(NUM_IN*SEL_W){1'b1}}};

  logic [TOT-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_flat <= RST_VAL;
      shadow   <= RST_VAL;
    end else begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (wr_ok && addr == ADDR_W'(IN_BASE + i)) begin
          cfg_flat[i*SEL_W +: SEL_W] <= wdata[SEL_W-1:0];
          shadow[i*SEL_W +: SEL_W]   <= wdata[SEL_W-1:0];
        end
      end
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_ok && addr == ADDR_W'(OUT_BASE + p/2)) begin
          cfg_flat[(NUM_IN+p)*SEL_W +: SEL_W] <= (p % 2 == 1) ? wdata[13:8] : wdata[5:0];
          shadow[(NUM_IN+p)*SEL_W +: SEL_W]   <= (p % 2 == 1) ? wdata[13:8] : wdata[5:0];
        end
      end
      if (inj_en && int'(inj_bit) < TOT)
        cfg_flat[inj_bit] <= ~cfg_flat[inj_bit];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mismatch <= 1'b0;
    else     mismatch <= mismatch | (cfg_flat != shadow);
  end
endmodule

// File: rtl/pxb_in_mux.sv
module pxb_in_mux
  import pxb_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_IN   = 6
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN*SEL_W-1:0]  sel_flat,
  input  logic [NUM_PINS-1:0]      pins,
  output logic [NUM_IN-1:0]        periph_in
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic nxt;
    always_comb begin
      nxt = 1'b0;
      for (int k = 0; k < NUM_PINS; k++)
        if (sel_flat[i*SEL_W +: SEL_W] == SEL_W'(k)) nxt = pins[k];
    end
    always_ff @(posedge clk) begin
      if (rst) periph_in[i] <= 1'b0;
      else     periph_in[i] <= nxt;
    end
  end
endmodule

// File: rtl/pxb_out_mux.sv
module pxb_out_mux
  import pxb_pkg::*;
#(
  parameter int NUM_PINS  = 8,
  parameter int NUM_CODES = 23
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS*SEL_W-1:0] sel_flat,
  input  logic [NUM_PINS-1:0]       gpio_dout,
  input  logic [NUM_PINS-1:0]       gpio_oe,
  input  logic [NUM_CODES-1:1]      per_out,
  input  logic [NUM_CODES-1:1]      per_oe,
  output logic [NUM_PINS-1:0]       pin_out,
  output logic [NUM_PINS-1:0]       pin_oe
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SEL_W-1:0] code;
    logic d_nxt, e_nxt;
    assign code = sel_flat[p*SEL_W +: SEL_W];
    always_comb begin
      d_nxt = 1'b0;
      e_nxt = 1'b0;
      if (code == '0) begin
        d_nxt = gpio_dout[p];
        e_nxt = gpio_oe[p];
      end else begin
        for (int c = 1; c < NUM_CODES; c++) begin
          if (code == SEL_W'(c)) begin
            d_nxt = per_out[c];
            e_nxt = per_oe[c];
          end
        end
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[p] <= 1'b0;
        pin_oe[p]  <= 1'b0;
      end else begin
        pin_out[p] <= d_nxt;
        pin_oe[p]  <= e_nxt;
      end
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pxb_pkg::*;
#(
  parameter int NUM_PINS  = 8,
  parameter int NUM_IN    = 6,
  parameter int NUM_CODES = 23,
  parameter int ADDR_W    = 5,
  localparam int IN_BASE  = 1,
  localparam int OUT_BASE = 16,
  localparam int TOT      = (NUM_IN + NUM_PINS) * SEL_W,
  localparam int INJ_W    = $clog2(TOT)
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic                 one_way_lock,
  input  logic                 fault_inj_en,
  input  logic [INJ_W-1:0]     fault_inj_bit,
  input  logic [NUM_PINS-1:0]  pin_in,
  input  logic [NUM_PINS-1:0]  gpio_dout,
  input  logic [NUM_PINS-1:0]  gpio_oe,
  input  logic [NUM_CODES-1:1] periph_out,
  input  logic [NUM_CODES-1:1] periph_oe,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic [NUM_IN-1:0]    periph_in,
  output logic                 cfg_mismatch
);
  logic           locked;
  logic           ctrl_wr;
  logic           other_wr;
  logic [TOT-1:0] cfg_flat;
  logic [BUS_W-1:0] rd_nxt;

  assign ctrl_wr  = bus_wr && (bus_addr == '0);
  assign other_wr = bus_wr && (bus_addr != '0);

  pxb_lock u_lock (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .other_wr(other_wr),
    .wbyte(bus_wdata[7:0]), .one_way(one_way_lock), .locked(locked)
  );

  pxb_cfg #(.NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN), .ADDR_W(ADDR_W),
            .IN_BASE(IN_BASE), .OUT_BASE(OUT_BASE)) u_cfg (
    .clk(clk), .rst(rst), .wr_ok(other_wr && !locked), .addr(bus_addr),
    .wdata(bus_wdata), .inj_en(fault_inj_en), .inj_bit(fault_inj_bit),
    .cfg_flat(cfg_flat), .mismatch(cfg_mismatch)
  );

  pxb_in_mux #(.NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN)) u_in (
    .clk(clk), .rst(rst), .sel_flat(cfg_flat[NUM_IN*SEL_W-1:0]),
    .pins(pin_in), .periph_in(periph_in)
  );

  pxb_out_mux #(.NUM_PINS(NUM_PINS), .NUM_CODES(NUM_CODES)) u_out (
    .clk(clk), .rst(rst), .sel_flat(cfg_flat[TOT-1:NUM_IN*SEL_W]),
    .gpio_dout(gpio_dout), .gpio_oe(gpio_oe), .per_out(periph_out),
    .per_oe(periph_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == '0) rd_nxt[0] = locked;
    for (int i = 0; i < NUM_IN; i++)
      if (bus_addr == ADDR_W'(IN_BASE + i))
        rd_nxt[SEL_W-1:0] = cfg_flat[i*SEL_W +: SEL_W];
    for (int m = 0; m < NUM_PINS/2; m++) begin
      if (bus_addr == ADDR_W'(OUT_BASE + m)) begin
        rd_nxt[5:0]  = cfg_flat[(NUM_IN+2*m)*SEL_W +: SEL_W];
        rd_nxt[13:8] = cfg_flat[(NUM_IN+2*m+1)*SEL_W +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import pxb_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_IN   = 6,
  parameter int ADDR_W   = 5,
  localparam int TOT     = (NUM_IN + NUM_PINS) * SEL_W
)(
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                fault_inj_en,
  input logic                one_way_lock,
  input logic                locked,
  input logic [TOT-1:0]      cfg_flat,
  input logic                cfg_mismatch,
  input logic [NUM_IN-1:0]   periph_in,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] gpio_dout,
  input logic [NUM_PINS-1:0] gpio_oe
);
  // R2
  reset_inputs_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (periph_in == '0));

  // R2
  unmapped_input_low_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(cfg_flat[SEL_W-1:0]) >= NUM_PINS) |=> !periph_in[0]);

  // R3
  gpio_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_flat[NUM_IN*SEL_W +: SEL_W] == '0) |=>
      (pin_out[0] == $past(gpio_dout[0]) && pin_oe[0] == $past(gpio_oe[0])));

  // R7
  locked_ignores_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && bus_wr && bus_addr != '0 && !fault_inj_en) |=> $stable(cfg_flat));

  // R10
  one_way_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (one_way_lock && locked) |=> locked);

  // R11
  mismatch_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_mismatch |=> cfg_mismatch);

  // R11
  mismatch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mismatch) |-> $past(fault_inj_en, 2));
endmodule

bind pin_xbar pin_xbar_chk #(.NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .fault_inj_en(fault_inj_en), .one_way_lock(one_way_lock), .locked(locked),
  .cfg_flat(cfg_flat), .cfg_mismatch(cfg_mismatch), .periph_in(periph_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .gpio_dout(gpio_dout), .gpio_oe(gpio_oe)
);

// File: tb/pin_xbar_test.sv
module pin_xbar_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [13:0] bus_wdata = '0;
  logic [13:0] bus_rdata;
  logic        one_way_lock = 0;
  logic        fault_inj_en = 0;
  logic [6:0]  fault_inj_bit = '0;
  logic [7:0]  pin_in = '0;
  logic [7:0]  gpio_dout = 8'hA5;
  logic [7:0]  gpio_oe = 8'h0F;
  logic [22:1] periph_out = '0;
  logic [22:1] periph_oe = '1;
  logic [7:0]  pin_out, pin_oe;
  logic [5:0]  periph_in;
  logic        cfg_mismatch;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pin_xbar uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .one_way_lock(one_way_lock),
    .fault_inj_en(fault_inj_en), .fault_inj_bit(fault_inj_bit), .pin_in(pin_in),
    .gpio_dout(gpio_dout), .gpio_oe(gpio_oe), .periph_out(periph_out),
    .periph_oe(periph_oe), .pin_out(pin_out), .pin_oe(pin_oe),
    .periph_in(periph_in), .cfg_mismatch(cfg_mismatch)
  );

  // {select value, pin pattern, expected periph_in[0]}
  localparam logic [14:0] VEC [8] = '{
    {6'd3,  8'b0000_1000, 1'b1},
    {6'd3,  8'b1111_0111, 1'b0},
    {6'd7,  8'b1000_0000, 1'b1},
    {6'd0,  8'b0000_0001, 1'b1},
    {6'd0,  8'b1111_1110, 1'b0},
    {6'd5,  8'b0010_0000, 1'b1},
    {6'd8,  8'b1111_1111, 1'b0},
    {6'd63, 8'b1111_1111, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [13:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [13:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic key(input logic v);
    wr(0, 14'h46);
    wr(0, 14'h57);
    wr(0, {13'd0, v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [13:0] r;
    pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 0;
    settle();
    check("R2 reset inputs low", periph_in, 6'h00);
    check("R3 reset gpio data", pin_out, 8'hA5);
    check("R3 reset gpio oe", pin_oe, 8'h0F);
    check("R11 reset no mismatch", cfg_mismatch, 0);
    rd(0, r);  check("R7 reset unlocked", r, 0);
    rd(1, r);  check("R2 reset select ones", r, 14'h3F);
    rd(16, r); check("R5 reset out select", r, 0);

    // R1 R2 table walk on input 0
    for (int n = 0; n < 8; n++) begin
      wr(1, {8'd0, VEC[n][14:9]});
      pin_in = VEC[n][8:1];
      settle();
      check("R1 R2 input routing", periph_in[0], VEC[n][0]);
    end

    // R12 one cycle latency
    wr(1, 14'd2);
    pin_in = 8'h00;
    settle();
    @(negedge clk);
    pin_in = 8'h04;
    #1 check("R12 not yet updated", periph_in[0], 0);
    @(negedge clk);
    check("R12 updated after one clock", periph_in[0], 1);

    // R3 gpio patterns
    gpio_dout = 8'h3C; gpio_oe = 8'hF0;
    settle();
    check("R3 gpio data", pin_out, 8'h3C);
    check("R3 gpio oe", pin_oe, 8'hF0);

    // R4 peripheral drive
    gpio_oe = 8'hFF;
    periph_out = '0; periph_out[3] = 1; periph_out[22] = 0;
    wr(16, 14'h1603);
    wr(17, 14'h0028);
    settle();
    check("R4 periph data pins 1:0", pin_out[1:0], 2'b01);
    check("R4 periph oe pins 1:0", pin_oe[1:0], 2'b11);
    check("R4 unimplemented code oe", pin_oe[2], 0);
    check("R4 unimplemented code data", pin_out[2], 0);
    check("R3 pin3 stays gpio", pin_out[3], gpio_dout[3]);
    periph_oe[3] = 0;
    settle();
    check("R4 oe follows peripheral", pin_oe[0], 0);
    periph_oe[3] = 1;

    // R5 packing and zero bits
    wr(16, 14'h3FFF);
    rd(16, r); check("R5 packed readback", r, 14'h3F3F);
    wr(16, 0); wr(17, 0);

    // R6 many-to-one and one-to-many
    wr(1, 14'd4); wr(2, 14'd4); wr(3, 14'd4);
    pin_in = 8'h10;
    periph_out[7] = 1;
    wr(18, 14'h0707);
    settle();
    check("R6 one pin to many inputs", periph_in[2:0], 3'b111);
    check("R6 one output to many pins", pin_out[5:4], 2'b11);

    // R7 R8 lock
    key(1);
    rd(0, r); check("R8 lock set by key", r, 1);
    wr(1, 14'd0);
    rd(1, r); check("R7 locked write ignored", r, 14'd4);
    key(0);
    rd(0, r); check("R8 lock cleared by key", r, 0);

    // R9 broken sequences
    wr(0, 14'h46); wr(0, 14'h12); wr(0, 14'h57); wr(0, 14'h01);
    rd(0, r); check("R9 wrong byte resets", r, 0);
    wr(0, 14'h46); wr(5, 14'h00); wr(0, 14'h57); wr(0, 14'h01);
    rd(0, r); check("R9 other address resets", r, 0);
    wr(0, 14'h46); wr(0, 14'h46); wr(0, 14'h57); wr(0, 14'h01);
    rd(0, r); check("R9 repeated first byte", r, 0);

    // R10 one-way
    one_way_lock = 1;
    key(1);
    key(0);
    rd(0, r); check("R10 clear blocked", r, 1);
    one_way_lock = 0;
    key(0);
    rd(0, r); check("R10 clear allowed when low", r, 0);
    check("R11 legal writes no mismatch", cfg_mismatch, 0);

    // R11 upset detection
    @(negedge clk);
    fault_inj_bit = 7'd3; fault_inj_en = 1;
    @(negedge clk);
    fault_inj_en = 0;
    #1 check("R11 not yet raised", cfg_mismatch, 0);
    @(negedge clk);
    check("R11 mismatch raised", cfg_mismatch, 1);
    wr(1, 14'd1);
    settle();
    check("R11 mismatch sticky", cfg_mismatch, 1);
    rst = 1;
    settle();
    rst = 0;
    settle();
    check("R11 cleared by reset", cfg_mismatch, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule